// File: doc/BRIEF.md
# Part-Wrapping Step Sequencer

This block runs the station that wraps one part at a time. It stays idle until the part sensor reports an arrival. It then clamps the part and drives three wrapping actuators one after another, each for its own fixed time: paper for 1 s, then crease for 0.5 s, then tape for 0.75 s. The clamp stays on during all three. After taping, the clamp opens and the sequencer waits for the sensor to report that the part has gone. Then it returns to idle.

Each step is one bit of a one-hot step register, and the step register is visible at the ports. All three timed steps share one step timer. A parameterised prescaler turns the clock into a 1 ms time base, and the timer restarts from zero whenever a new step is entered. A stop input returns the sequencer to idle from any step. A new cycle starts only on a fresh arrival, meaning the sensor must be seen inactive and then active again while the sequencer is idle.

Top module: `wrap_seq`

## Requirements
- R1: While reset is applied, and in the cycles after it is released, the step vector equals 5'b00001 (idle) and hold, paper, crease and tape are all low. Step bits are: bit0 idle, bit1 paper, bit2 crease, bit3 tape, bit4 release.
- R2: In idle, if the part sensor is high in a cycle where it was low in the previous cycle, the paper step (5'b00010) is entered in the next cycle. Hold and paper then go high.
- R3: The paper step lasts exactly PAPER_MS × CLK_PER_MS cycles.
- R4: After paper, the crease step (5'b00100) lasts exactly CREASE_MS × CLK_PER_MS cycles.
- R5: After crease, the tape step (5'b01000) lasts exactly TAPE_MS × CLK_PER_MS cycles.
- R6: Hold is high in every cycle of the paper, crease and tape steps, and low in the idle and release steps.
- R7: After tape, the release step (5'b10000) is held for as long as the part sensor is high. Idle is entered in the cycle after the sensor is seen low. If the sensor went low earlier, this happens in the cycle after release is entered.
- R8: When stop is high, all four actuator outputs are low in that same cycle, and the step vector is idle in the next cycle. This holds from any step.
- R9: The step vector always has exactly one bit set, and at most one of paper, crease and tape is high in any cycle.
- R10: A part sensor that stays high in idle, including one that is high when reset is released or when a stop ends, starts no new cycle until it has been seen low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| part_i | input | 1 | Part-present sensor, high while a part is at the station |
| stop_i | input | 1 | Stop request, returns to idle |
| hold_o | output | 1 | Clamp actuator enable |
| paper_o | output | 1 | Paper actuator enable |
| crease_o | output | 1 | Crease actuator enable |
| tape_o | output | 1 | Tape actuator enable |
| step_o | output | 5 | One-hot step vector |

## Verification
The bench builds the block with CLK_PER_MS=3, PAPER_MS=4, CREASE_MS=2 and TAPE_MS=3. A whole wrap then takes 27 cycles, so every cycle of every step can be compared against a step position computed arithmetically from the cycle count. Because the sequence is this short, a stop can be injected at every single offset from the first paper cycle into the release wait. The sensor can also be dropped at several points, both early and late. Each of these runs checks that no new cycle starts while the sensor is still high.

// File: rtl/wrap_seq_pkg.sv
package wrap_seq_pkg;
  localparam int NSTEP       = 5;
  localparam int IDX_IDLE    = 0;
  localparam int IDX_PAPER   = 1;
  localparam int IDX_CREASE  = 2;
  localparam int IDX_TAPE    = 3;
  localparam int IDX_RELEASE = 4;

  typedef logic [NSTEP-1:0] step_vec_t;

  function automatic step_vec_t one_step(input int idx);
    return step_vec_t'(1) << idx;
  endfunction
endpackage

// File: rtl/wrap_tick_gen.sv
module wrap_tick_gen #(
  parameter int CLK_PER_MS = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_MS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = en_i & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else if (en_i)   cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wrap_ms_timer.sv
module wrap_ms_timer #(
  parameter int MSW = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           tick_i,
  input  logic [MSW-1:0] limit_i,
  output logic           done_o
);
  logic [MSW-1:0] ms_q, ms_d;

  assign done_o = tick_i & (ms_q == (limit_i - MSW'(1)));

  always_comb begin
    ms_d = ms_q;
    if (clr_i)       ms_d = '0;
    else if (tick_i) ms_d = ms_q + MSW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ms_q <= '0;
    else         ms_q <= ms_d;
  end
endmodule

// File: rtl/wrap_step_ctrl.sv
module wrap_step_ctrl
  import wrap_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      part_i,
  input  logic      stop_i,
  input  logic      done_i,
  output step_vec_t step_o,
  output logic      adv_o,
  output logic      timed_o
);
  step_vec_t step_q, step_d;
  logic      part_q;
  logic      start;

  assign start   = step_q[IDX_IDLE] & part_i & ~part_q;
  assign timed_o = step_q[IDX_PAPER] | step_q[IDX_CREASE] | step_q[IDX_TAPE];
  assign adv_o   = (step_d != step_q);
  assign step_o  = step_q;

  always_comb begin
    step_d = step_q;
    if (stop_i) begin
      step_d = one_step(IDX_IDLE);
    end else begin
      if (start)                           step_d = one_step(IDX_PAPER);
      if (step_q[IDX_PAPER]  && done_i)    step_d = one_step(IDX_CREASE);
      if (step_q[IDX_CREASE] && done_i)    step_d = one_step(IDX_TAPE);
      if (step_q[IDX_TAPE]   && done_i)    step_d = one_step(IDX_RELEASE);
      if (step_q[IDX_RELEASE] && !part_i)  step_d = one_step(IDX_IDLE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= one_step(IDX_IDLE);
      part_q <= 1'b1;
    end else begin
      step_q <= step_d;
      part_q <= part_i;
    end
  end
endmodule

// File: rtl/wrap_seq.sv
module wrap_seq
  import wrap_seq_pkg::*;
#(
  parameter int CLK_PER_MS = 100000,
  parameter int PAPER_MS   = 1000,
  parameter int CREASE_MS  = 500,
  parameter int TAPE_MS    = 750
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             part_i,
  input  logic             stop_i,
  output logic             hold_o,
  output logic             paper_o,
  output logic             crease_o,
  output logic             tape_o,
  output logic [NSTEP-1:0] step_o
);
  localparam int MAX_PC = (PAPER_MS > CREASE_MS) ? PAPER_MS : CREASE_MS;
  localparam int MAX_MS = (MAX_PC > TAPE_MS) ? MAX_PC : TAPE_MS;
  localparam int MSW    = $clog2(MAX_MS + 1);

  logic [1:0]     rst_sync_q;
  logic           rst_n_int;
  step_vec_t      step;
  logic           adv, timed, tick, done;
  logic [MSW-1:0] limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  always_comb begin
    if (step[IDX_PAPER])       limit = MSW'(PAPER_MS);
    else if (step[IDX_CREASE]) limit = MSW'(CREASE_MS);
    else                       limit = MSW'(TAPE_MS);
  end

  wrap_tick_gen #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
    .clk_i (clk_i), .rst_ni (rst_n_int), .clr_i (adv),
    .en_i  (timed), .tick_o (tick)
  );

  wrap_ms_timer #(.MSW(MSW)) u_timer (
    .clk_i  (clk_i), .rst_ni (rst_n_int), .clr_i (adv),
    .tick_i (tick),  .limit_i (limit),    .done_o (done)
  );

  wrap_step_ctrl u_ctrl (
    .clk_i  (clk_i),  .rst_ni (rst_n_int), .part_i  (part_i),
    .stop_i (stop_i), .done_i (done),      .step_o  (step),
    .adv_o  (adv),    .timed_o (timed)
  );

  assign step_o   = step;
  assign hold_o   = ~stop_i & timed;
  assign paper_o  = ~stop_i & step[IDX_PAPER];
  assign crease_o = ~stop_i & step[IDX_CREASE];
  assign tape_o   = ~stop_i & step[IDX_TAPE];
endmodule

// File: rtl/wrap_seq_chk.sv
module wrap_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       part_i,
  input logic       stop_i,
  input logic       hold_o,
  input logic       paper_o,
  input logic       crease_o,
  input logic       tape_o,
  input logic [4:0] step_o
);
  p_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(step_o) == 1);

  p_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({paper_o, crease_o, tape_o}));

  p_hold_span_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paper_o || crease_o || tape_o) |-> hold_o);

  p_stop_outputs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !(hold_o || paper_o || crease_o || tape_o));

  p_stop_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (step_o == 5'b00001));

  p_release_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o[4] && part_i && !stop_i) |=> step_o[4]);

  p_release_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o[4] && !part_i && !stop_i) |=> step_o[0]);

  p_idle_no_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o[0] && part_i && $past(part_i)) |=> step_o[0]);

  p_paper_to_crease_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o[1] && !stop_i) |=> (step_o[1] || step_o[2]));
endmodule

bind wrap_seq wrap_seq_chk u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .part_i (part_i), .stop_i (stop_i),
  .hold_o (hold_o), .paper_o (paper_o), .crease_o (crease_o),
  .tape_o (tape_o), .step_o (step_o)
);

// File: tb/wrap_seq_bench.sv
module wrap_seq_bench;
  localparam int N  = 3;
  localparam int PM = 4;
  localparam int CM = 2;
  localparam int TM = 3;
  localparam int P_END = PM * N;
  localparam int C_END = P_END + CM * N;
  localparam int T_END = C_END + TM * N;

  logic clk = 1'b0;
  logic rst_n, part, stop;
  logic hold, paper, crease, tape;
  logic [4:0] step;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  wrap_seq #(.CLK_PER_MS(N), .PAPER_MS(PM), .CREASE_MS(CM), .TAPE_MS(TM)) u_wrap_seq (
    .clk_i (clk), .rst_ni (rst_n), .part_i (part), .stop_i (stop),
    .hold_o (hold), .paper_o (paper), .crease_o (crease), .tape_o (tape),
    .step_o (step)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_step(input int t);
    if (t < P_END) return 5'b00010;
    if (t < C_END) return 5'b00100;
    if (t < T_END) return 5'b01000;
    return 5'b10000;
  endfunction

  function automatic string region_tag(input int t);
    if (t < P_END) return "R3 paper";
    if (t < C_END) return "R4 crease";
    if (t < T_END) return "R5 tape";
    return "R7 release";
  endfunction

  // sample shortly after the falling edge, inputs already driven
  task automatic sample(input string tag, input logic [4:0] es, input bit stopped);
    logic [3:0] eo;
    #1;
    eo = stopped ? 4'b0000 : {|es[3:1], es[1], es[2], es[3]};
    check({tag, " step"}, int'(step), int'(es));
    check({tag, " R6 outputs"}, int'({hold, paper, crease, tape}), int'(eo));
    check("R9 onehot", $countones(step), 1);
  endtask

  task automatic idle_cycles(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample(tag, 5'b00001, 1'b0);
    end
  endtask

  // stop_at < 0: no stop; rel_at: cycle index at which part drops
  task automatic run_seq(input int stop_at, input int rel_at);
    @(negedge clk);
    part = 1'b1;
    sample("R2 arrival seen", 5'b00001, 1'b0);
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (t == stop_at) stop = 1'b1;
      if (t == rel_at)  part = 1'b0;
      sample(region_tag(t), exp_step(t), stop);
      if (stop) begin
        @(negedge clk);
        stop = 1'b0;
        sample("R8 stop to idle", 5'b00001, 1'b0);
        idle_cycles("R10 no restart after stop", part ? 3 : 1);
        part = 1'b0;
        idle_cycles("R10 sensor low", 1);
        return;
      end
      if (t >= T_END && !part) begin
        @(negedge clk);
        sample("R7 back to idle", 5'b00001, 1'b0);
        return;
      end
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    part  = 1'b1;
    stop  = 1'b0;
    repeat (2) @(negedge clk);
    sample("R1 in reset", 5'b00001, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    sample("R1 after reset", 5'b00001, 1'b0);
    idle_cycles("R10 part high at reset", 6);
    part = 1'b0;
    idle_cycles("R1 idle", 2);

    for (int r = T_END; r < T_END + 4; r++) run_seq(-1, r);
    run_seq(-1, 5);
    run_seq(-1, C_END + 1);
    for (int k = 0; k <= T_END + 2; k++) run_seq(k, T_END + 3);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule